// File: doc/BRIEF.md
# Register-Immediate Execute Unit

This block is the combinational execute step for register-immediate instructions on a 64-bit integer datapath. The decoder supplies a 3-bit operation code, the source register value and the 16-bit immediate field. The processor state supplies two mode bits: one for the 32-bit compatibility mode and one for privileged (kernel) execution. Within the same cycle the unit returns the value to write back, a write strobe, and two mutually exclusive exception flags. One flag reports signed overflow. The other reports a 64-bit operation attempted where it is not permitted.

The unit supports six operations: a 32-bit add that traps on overflow, a 32-bit add that wraps, an AND with a zero-extended immediate, a load of the immediate into the upper half-word, and a trapping and a wrapping 64-bit add. Results of 32-bit width are sign-extended into the 64-bit destination. When an exception is raised, the write strobe stays low so the destination keeps its old value. Register file access, pipeline registers and exception vectoring belong to the surrounding core.

Top module: `imm_exec_unit`

## Requirements
- R1: Opcode 0 (trapping 32-bit add): result is the low 32 bits of the source plus the sign-extended immediate, sign-extended from bit 31 to 64 bits; the write strobe is high when no overflow occurs.
- R2: Opcode 0 with 32-bit signed overflow (both addends share a sign and bit 31 of the sum differs from it) raises the overflow flag and holds the write strobe low.
- R3: Opcode 1 (wrapping 32-bit add) gives the same sign-extended 32-bit sum as R1, always writes, and never raises the overflow flag.
- R4: Opcode 2 (AND immediate) gives the source ANDed with the zero-extended immediate, so bits 63..16 of the result are zero; it always writes and raises no flag.
- R5: Opcode 3 (load upper) gives the immediate placed in bits 31..16 with zeros below, sign-extended from bit 31; it always writes and raises no flag.
- R6: Opcodes 4 and 5 (64-bit adds) with the 32-bit-mode bit high and the kernel bit low raise the illegal-instruction flag, hold the write strobe low and do not raise the overflow flag, even when the sum would overflow.
- R7: Opcode 5 (wrapping 64-bit add), when permitted, gives the full 64-bit source plus the sign-extended immediate and always writes.
- R8: Opcode 4 (trapping 64-bit add), when permitted, gives the same 64-bit sum as R7; on 64-bit signed overflow it raises the overflow flag and holds the write strobe low, otherwise it writes.
- R9: At most one exception flag is high at a time, and the write strobe is low whenever any flag is high.
- R10: Opcodes 6 and 7 are unused: the write strobe and both flags stay low and the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code (0..5 defined, 6..7 unused) |
| rs_i | input | 64 | Source register value |
| imm_i | input | 16 | Immediate field from the instruction |
| mode32_i | input | 1 | 32-bit compatibility mode is active |
| kernel_i | input | 1 | Processor runs in kernel mode |
| result_o | output | 64 | Value to write to the destination register |
| wr_en_o | output | 1 | Destination write strobe |
| exc_ovf_o | output | 1 | Signed overflow exception |
| exc_ill_o | output | 1 | Illegal-instruction exception for a forbidden 64-bit add |

## Verification
Assertions placed beside the logic check invariants on every input combination. Exception flags are exclusive and suppress the write. The wrapping 32-bit add never flags overflow. The illegal flag appears only for a 64-bit add in user 32-bit mode. A 32-bit overflow is reported only when the addends share a sign. The logical and upper-load operations never raise a flag. The actual result values, the sign extension of 32-bit sums and the exact overflow boundaries can only be shown by the bench. It compares every output against a reference model across random operands and directed corner cases: the most positive and most negative values, carries across bit 31, and every combination of the mode bits.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;

   typedef enum logic [2:0] {
      OP_ADD32_TRAP = 3'd0,
      OP_ADD32_WRAP = 3'd1,
      OP_AND_ZIMM   = 3'd2,
      OP_LOAD_UPPER = 3'd3,
      OP_ADD64_TRAP = 3'd4,
      OP_ADD64_WRAP = 3'd5
   } imm_op_e;

   typedef enum logic [2:0] {
      SEL_NONE   = 3'd0,
      SEL_NARROW = 3'd1,
      SEL_WIDE   = 3'd2,
      SEL_AND    = 3'd3,
      SEL_UPPER  = 3'd4
   } res_sel_e;

   function automatic logic is_wide_add(input logic [2:0] op);
      return (op == OP_ADD64_TRAP) || (op == OP_ADD64_WRAP);
   endfunction

endpackage

// File: rtl/imm_operand_ext.sv
module imm_operand_ext #(
   parameter int IMM_W = 16,
   parameter int OUT_W = 64,
   parameter int UP_W  = 32
) (
   input  logic [IMM_W-1:0] imm_i,
   output logic [OUT_W-1:0] sext_o,
   output logic [OUT_W-1:0] zext_o,
   output logic [OUT_W-1:0] upper_o
);
   localparam int SHIFT = UP_W - IMM_W;
   localparam int SEXT_PAD = OUT_W - IMM_W;
   localparam int UP_PAD = OUT_W - UP_W;

   if (UP_W < IMM_W || OUT_W < UP_W) begin : g_bad_width
      $error("imm_operand_ext: widths must satisfy IMM_W <= UP_W <= OUT_W");
   end

   logic [UP_W-1:0] upper_narrow;

   always_comb begin
      sext_o = {{SEXT_PAD{imm_i[IMM_W-1]}}, imm_i};
      zext_o = {{SEXT_PAD{1'b0}}, imm_i};
      upper_narrow = {imm_i, {SHIFT{1'b0}}};
   end

   if (UP_PAD > 0) begin : g_up_pad
      assign upper_o = {{UP_PAD{upper_narrow[UP_W-1]}}, upper_narrow};
   end else begin : g_up_flat
      assign upper_o = upper_narrow;
   end
endmodule

// File: rtl/imm_signed_adder.sv
module imm_signed_adder #(
   parameter int W = 32,
   parameter bit CARRY_OVF = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o,
   output logic         ovf_o
);
   if (W < 2) begin : g_bad_width
      $error("imm_signed_adder: W must be at least 2");
   end

   if (CARRY_OVF) begin : g_carry
      logic [W-1:0] low_sum;
      logic         c_out;
      assign low_sum = {1'b0, a_i[W-2:0]} + {1'b0, b_i[W-2:0]};
      assign {c_out, sum_o} = {1'b0, a_i} + {1'b0, b_i};
      assign ovf_o = low_sum[W-1] ^ c_out;
   end else begin : g_sign
      assign sum_o = a_i + b_i;
      assign ovf_o = (a_i[W-1] == b_i[W-1]) && (sum_o[W-1] != a_i[W-1]);
   end
endmodule

// File: rtl/imm_issue_ctrl.sv
module imm_issue_ctrl
   import imm_exec_pkg::*;
(
   input  logic [2:0] op_i,
   input  logic       mode32_i,
   input  logic       kernel_i,
   input  logic       ovf_narrow_i,
   input  logic       ovf_wide_i,
   output res_sel_e   sel_o,
   output logic       wr_en_o,
   output logic       exc_ovf_o,
   output logic       exc_ill_o
);
   logic wide_blocked;

   always_comb begin
      wide_blocked = is_wide_add(op_i) && mode32_i && !kernel_i;
      sel_o     = SEL_NONE;
      wr_en_o   = 1'b0;
      exc_ovf_o = 1'b0;
      exc_ill_o = 1'b0;
      case (op_i)
         OP_ADD32_TRAP: begin
            sel_o = SEL_NARROW;
            if (ovf_narrow_i) exc_ovf_o = 1'b1;
            else              wr_en_o   = 1'b1;
         end
         OP_ADD32_WRAP: begin
            sel_o   = SEL_NARROW;
            wr_en_o = 1'b1;
         end
         OP_AND_ZIMM: begin
            sel_o   = SEL_AND;
            wr_en_o = 1'b1;
         end
         OP_LOAD_UPPER: begin
            sel_o   = SEL_UPPER;
            wr_en_o = 1'b1;
         end
         OP_ADD64_TRAP: begin
            sel_o = SEL_WIDE;
            if (wide_blocked)    exc_ill_o = 1'b1;
            else if (ovf_wide_i) exc_ovf_o = 1'b1;
            else                 wr_en_o   = 1'b1;
         end
         OP_ADD64_WRAP: begin
            sel_o = SEL_WIDE;
            if (wide_blocked) exc_ill_o = 1'b1;
            else              wr_en_o   = 1'b1;
         end
         default: begin
            sel_o = SEL_NONE;
         end
      endcase
   end
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
   import imm_exec_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int NARROW_W  = 32,
   parameter int IMM_W     = 16,
   parameter bit CARRY_OVF = 1'b0
) (
   input  logic [2:0]      op_i,
   input  logic [XLEN-1:0] rs_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic            mode32_i,
   input  logic            kernel_i,
   output logic [XLEN-1:0] result_o,
   output logic            wr_en_o,
   output logic            exc_ovf_o,
   output logic            exc_ill_o
);
   localparam int PAD_W = XLEN - NARROW_W;

   if (NARROW_W < IMM_W || XLEN <= NARROW_W) begin : g_bad_cfg
      $error("imm_exec_unit: need IMM_W <= NARROW_W < XLEN");
   end

   logic [XLEN-1:0]     imm_sext, imm_zext, imm_upper;
   logic [NARROW_W-1:0] sum_narrow;
   logic [XLEN-1:0]     sum_wide;
   logic                ovf_narrow, ovf_wide;
   res_sel_e            sel;

   imm_operand_ext #(.IMM_W(IMM_W), .OUT_W(XLEN), .UP_W(NARROW_W)) u_ext (
      .imm_i  (imm_i),
      .sext_o (imm_sext),
      .zext_o (imm_zext),
      .upper_o(imm_upper)
   );

   imm_signed_adder #(.W(NARROW_W), .CARRY_OVF(CARRY_OVF)) u_add_narrow (
      .a_i  (rs_i[NARROW_W-1:0]),
      .b_i  (imm_sext[NARROW_W-1:0]),
      .sum_o(sum_narrow),
      .ovf_o(ovf_narrow)
   );

   imm_signed_adder #(.W(XLEN), .CARRY_OVF(CARRY_OVF)) u_add_wide (
      .a_i  (rs_i),
      .b_i  (imm_sext),
      .sum_o(sum_wide),
      .ovf_o(ovf_wide)
   );

   imm_issue_ctrl u_ctrl (
      .op_i        (op_i),
      .mode32_i    (mode32_i),
      .kernel_i    (kernel_i),
      .ovf_narrow_i(ovf_narrow),
      .ovf_wide_i  (ovf_wide),
      .sel_o       (sel),
      .wr_en_o     (wr_en_o),
      .exc_ovf_o   (exc_ovf_o),
      .exc_ill_o   (exc_ill_o)
   );

   always_comb begin
      case (sel)
         SEL_NARROW: result_o = {{PAD_W{sum_narrow[NARROW_W-1]}}, sum_narrow};
         SEL_WIDE:   result_o = sum_wide;
         SEL_AND:    result_o = rs_i & imm_zext;
         SEL_UPPER:  result_o = imm_upper;
         default:    result_o = '0;
      endcase
   end

   always_comb begin
      AST_ONE_EXCEPTION: assert ($onehot0({exc_ovf_o, exc_ill_o}))
         else $error("two exception flags at once"); // R9
      AST_WRITE_SUPPRESSED: assert (!(wr_en_o && (exc_ovf_o || exc_ill_o)))
         else $error("write while an exception is raised"); // R9
      AST_WRAP_NO_OVERFLOW: assert (!(op_i == OP_ADD32_WRAP && exc_ovf_o))
         else $error("wrapping add raised overflow"); // R3
      AST_ILLEGAL_ONLY_USER32: assert (!exc_ill_o || (is_wide_add(op_i) && mode32_i && !kernel_i))
         else $error("illegal flag outside user 32-bit mode"); // R6
      AST_NARROW_OVF_SIGNS: assert (!(op_i == OP_ADD32_TRAP && exc_ovf_o)
                                    || (rs_i[NARROW_W-1] == imm_i[IMM_W-1]))
         else $error("overflow with addends of opposite sign"); // R2
      AST_LOGIC_NO_EXC: assert (!((op_i == OP_AND_ZIMM || op_i == OP_LOAD_UPPER)
                                  && (exc_ovf_o || exc_ill_o || !wr_en_o)))
         else $error("logical operation did not write cleanly"); // R4
      AST_UNUSED_IDLE: assert (!(op_i[2:1] == 2'b11 && (wr_en_o || exc_ovf_o || exc_ill_o)))
         else $error("unused opcode had an effect"); // R10
   end
endmodule

// File: tb/imm_exec_unit_bench.sv
module imm_exec_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM = 800;

   logic        clk = 1'b0;
   logic [2:0]  op;
   logic [63:0] rs;
   logic [15:0] imm;
   logic        mode32, kernel;
   logic [63:0] result;
   logic        wr_en, exc_ovf, exc_ill;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   imm_exec_unit u_imm_exec_unit (
      .op_i(op), .rs_i(rs), .imm_i(imm), .mode32_i(mode32), .kernel_i(kernel),
      .result_o(result), .wr_en_o(wr_en), .exc_ovf_o(exc_ovf), .exc_ill_o(exc_ill)
   );

   typedef struct packed {
      logic [63:0] res;
      logic        we;
      logic        ovf;
      logic        ill;
   } exp_t;

   function automatic exp_t model(input logic [2:0] o, input logic [63:0] s,
                                  input logic [15:0] i, input logic m32, input logic k);
      exp_t e;
      logic [63:0] si = {{48{i[15]}}, i};
      logic [31:0] s32 = s[31:0] + si[31:0];
      logic [63:0] s64 = s + si;
      logic o32 = (s[31] == i[15]) && (s32[31] != s[31]);
      logic o64 = (s[63] == i[15]) && (s64[63] != s[63]);
      logic blk = m32 && !k;
      e = '0;
      case (o)
         3'd0: begin e.res = {{32{s32[31]}}, s32}; e.ovf = o32; e.we = !o32; end
         3'd1: begin e.res = {{32{s32[31]}}, s32}; e.we = 1'b1; end
         3'd2: begin e.res = s & {48'd0, i}; e.we = 1'b1; end
         3'd3: begin e.res = {{32{i[15]}}, i, 16'd0}; e.we = 1'b1; end
         3'd4: begin
            e.res = s64;
            if (blk) e.ill = 1'b1;
            else begin e.ovf = o64; e.we = !o64; end
         end
         3'd5: begin e.res = s64; if (blk) e.ill = 1'b1; else e.we = 1'b1; end
         default: e.res = '0;
      endcase
      return e;
   endfunction

   function automatic string tag_of(input logic [2:0] o, input exp_t e);
      case (o)
         3'd0: return e.ovf ? "R2" : "R1";
         3'd1: return "R3";
         3'd2: return "R4";
         3'd3: return "R5";
         3'd4: return e.ill ? "R6" : "R8";
         3'd5: return e.ill ? "R6" : "R7";
         default: return "R10";
      endcase
   endfunction

   task automatic apply(input logic [2:0] o, input logic [63:0] s, input logic [15:0] i,
                        input logic m32, input logic k);
      exp_t e;
      string t;
      @(negedge clk);
      op = o; rs = s; imm = i; mode32 = m32; kernel = k;
      #1;
      e = model(o, s, i, m32, k);
      t = tag_of(o, e);
      checks++;
      if (wr_en !== e.we || exc_ovf !== e.ovf || exc_ill !== e.ill
          || ((e.we || o[2:1] == 2'b11) && result !== e.res)) begin
         fails++;
         $display("FAIL %s op=%0d rs=%h imm=%h: got res=%h we=%b ovf=%b ill=%b exp res=%h we=%b ovf=%b ill=%b",
                  t, o, s, i, result, wr_en, exc_ovf, exc_ill, e.res, e.we, e.ovf, e.ill);
      end
      checks++;
      if ((exc_ovf && exc_ill) || (wr_en && (exc_ovf || exc_ill))) begin
         fails++;
         $display("FAIL R9 op=%0d: got we=%b ovf=%b ill=%b exp exclusive flags and no write",
                  o, wr_en, exc_ovf, exc_ill);
      end
   endtask

   function automatic logic [63:0] pick_rs();
      case ($urandom % 6)
         0: return 64'h0000_0000_7FFF_FFFF;
         1: return 64'hFFFF_FFFF_8000_0000;
         2: return 64'h7FFF_FFFF_FFFF_FFFF;
         3: return 64'h8000_0000_0000_0000;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'd20240611);
      op = 3'd6; rs = '0; imm = '0; mode32 = 1'b0; kernel = 1'b0;
      #1;
      // Idle state on an unused opcode (R10)
      checks++;
      if (wr_en !== 1'b0 || exc_ovf !== 1'b0 || exc_ill !== 1'b0 || result !== '0) begin
         fails++;
         $display("FAIL R10 idle: got res=%h we=%b ovf=%b ill=%b exp 0 0 0 0",
                  result, wr_en, exc_ovf, exc_ill);
      end
      // Directed corners
      apply(3'd0, 64'h0000_0000_7FFF_FFFF, 16'h0001, 1'b0, 1'b0); // R2 positive overflow
      apply(3'd0, 64'hFFFF_FFFF_8000_0000, 16'hFFFF, 1'b0, 1'b0); // R2 negative overflow
      apply(3'd0, 64'h1234_5678_7FFF_FFFE, 16'h0001, 1'b0, 1'b0); // R1 reach max, upper bits ignored
      apply(3'd0, 64'h0000_0000_0000_0005, 16'hFFFA, 1'b0, 1'b0); // R1 negative result sign-extends
      apply(3'd1, 64'h0000_0000_7FFF_FFFF, 16'h0001, 1'b1, 1'b0); // R3 wraps silently
      apply(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 16'h8421, 1'b0, 1'b0); // R4 upper bits cleared
      apply(3'd3, 64'h0, 16'h8000, 1'b1, 1'b0);                   // R5 negative upper
      apply(3'd3, 64'h0, 16'h7FFF, 1'b0, 1'b1);                   // R5 positive upper
      apply(3'd4, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0001, 1'b1, 1'b0); // R6 wins over overflow
      apply(3'd5, 64'h10, 16'h0001, 1'b1, 1'b0);                  // R6 wrapping blocked
      apply(3'd5, 64'h10, 16'hFFFF, 1'b1, 1'b1);                  // R7 kernel in 32-bit mode
      apply(3'd5, 64'h0000_0000_FFFF_FFFF, 16'h0001, 1'b0, 1'b0); // R7 carry past bit 31
      apply(3'd4, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0001, 1'b0, 1'b0); // R8 overflow
      apply(3'd4, 64'h8000_0000_0000_0000, 16'hFFFF, 1'b0, 1'b1); // R8 negative overflow
      apply(3'd4, 64'h0000_0000_7FFF_FFFF, 16'h0001, 1'b0, 1'b0); // R8 no 64-bit overflow
      apply(3'd7, 64'hDEAD_BEEF_0000_0001, 16'h1234, 1'b0, 1'b1); // R10
      // Random mix
      for (int n = 0; n < N_RANDOM; n++) begin
         apply(3'($urandom % 8), pick_rs(), 16'($urandom), 1'($urandom), 1'($urandom));
      end
      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout exp completion");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule